// File: doc/BRIEF.md
# Bounded Descending Stack Controller

This unit keeps the stack pointer for a processor whose stack sits in a fixed 22-byte window at the top of a 256-byte memory, from 0xFF down to 0xEA. It takes one operation per cycle: a data push, a data pop, a subroutine call or a subroutine return. For each operation it drives the memory address, a write or read strobe and the write data, and it moves the pointer. The memory array, the register file and the program counter are outside the unit. Pop data comes back from memory in the same cycle. The unit registers the result and presents it one cycle later as register-file write data or as a program-counter load.

The pointer always names the next free slot. A push writes at the pointer and then steps it down. A pop steps it up and reads at the new position. Pushing into a full window or popping from an empty one is refused: memory and the pointer are left alone, and a sticky error flag is raised that only reset clears.

Top module: `stk_unit`

## Requirements
- R1: After reset the pointer reads 0xFF (empty), both error flags are 0, and done, rd_valid and pc_load are 0.
- R2: A push (op_kind 2'b00) on a non-full stack drives mem_we=1 with mem_addr equal to the current pointer and mem_wdata equal to wr_data in that cycle. The pointer then drops by one, and done is 1 in the next cycle.
- R3: A pop (op_kind 2'b01) on a non-empty stack drives mem_re=1 with mem_addr equal to the pointer plus one. The pointer then rises by one, and in the next cycle done=1, rd_valid=1 and rd_data holds the byte read.
- R4: Twenty-two pushes with no pops fill addresses 0xFF down to 0xEA in that order and leave the pointer at 0xE9. The following pops return the values in reverse order.
- R5: A push or call while the pointer is 0xE9 (full) produces no write and no done, leaves the pointer unchanged, and sets ovf_err.
- R6: A pop or return while the pointer is 0xFF (empty) produces no memory access and no done, leaves the pointer unchanged, and sets udf_err.
- R7: A call (op_kind 2'b10) writes ret_addr like a push. In the next cycle pc_load=1 with pc_value equal to call_target, and done=1.
- R8: A return (op_kind 2'b11) reads like a pop. In the next cycle pc_load=1 with pc_value equal to the byte read, rd_valid=0 and done=1.
- R9: ovf_err and udf_err stay set through later accepted operations until reset, and reset clears them.
- R10: mem_we and mem_re are never both 1, and neither is 1 when op_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 2 | 00 push, 01 pop, 10 call, 11 return |
| wr_data | input | 8 | Register value for a push |
| ret_addr | input | 8 | Return address for a call |
| call_target | input | 8 | Jump target for a call |
| mem_addr | output | 8 | Memory address for the access |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| done | output | 1 | Pulse one cycle after an accepted operation |
| rd_valid | output | 1 | Pop result is valid for the register file |
| rd_data | output | 8 | Popped register value |
| pc_load | output | 1 | Program counter must load pc_value |
| pc_value | output | 8 | Call target or returned address |
| sp | output | 8 | Current stack pointer |
| ovf_err | output | 1 | Sticky overflow flag |
| udf_err | output | 1 | Sticky underflow flag |

## Verification
The assertions check four things on every cycle. The pointer stays inside 0xE9..0xFF and moves by at most one. No strobe fires on a full push or an empty pop. A refused operation leaves the pointer still and raises its flag. The error flags never fall outside reset. Only the bench scenarios can show that data comes back in last-in, first-out order through a real memory, that a call and a return move the right addresses to the program counter, and that the window takes exactly 22 bytes before it refuses.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_CALL = 2'b10,
    OP_RET  = 2'b11
  } stk_op_e;

  // Push-like operations store a byte; pop-like ones fetch one.
  function automatic logic op_stores(input stk_op_e k);
    return (k == OP_PUSH) || (k == OP_CALL);
  endfunction

  function automatic logic op_is_ctrl(input stk_op_e k);
    return (k == OP_CALL) || (k == OP_RET);
  endfunction
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int unsigned AW  = 8,
  parameter int unsigned TOP = 255,
  parameter int unsigned BOT = 234
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_dn,
  input  logic          step_up,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] pop_slot,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0] TOP_A  = AW'(TOP);
  localparam logic [AW-1:0] FULL_A = AW'(BOT - 1);

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p,
                                             input logic dn, input logic up);
    if (dn)      return p - AW'(1);
    else if (up) return p + AW'(1);
    else         return p;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp <= TOP_A;
    else        sp <= next_ptr(sp, step_dn, step_up);
  end

  assign pop_slot = sp + AW'(1);
  assign full     = (sp == FULL_A);
  assign empty    = (sp == TOP_A);

  // R4: pointer never leaves the window
  assert_ptr_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sp >= FULL_A) && (sp <= TOP_A));
  // R2 R3: at most one step per cycle
  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sp != $past(sp)) |-> ((sp == $past(sp) - AW'(1)) || (sp == $past(sp) + AW'(1))));
endmodule

// File: rtl/stk_gate.sv
module stk_gate
  import stk_pkg::*;
(
  input  logic    op_valid,
  input  stk_op_e kind,
  input  logic    full,
  input  logic    empty,
  output logic    push_ok,
  output logic    pop_ok,
  output logic    ovf_hit,
  output logic    udf_hit
);
  logic wants_store, wants_fetch;

  always_comb begin
    wants_store = op_valid && op_stores(kind);
    wants_fetch = op_valid && !op_stores(kind);
    push_ok = wants_store && !full;
    pop_ok  = wants_fetch && !empty;
    ovf_hit = wants_store && full;
    udf_hit = wants_fetch && empty;
  end
endmodule

// File: rtl/stk_resp.sv
module stk_resp
  import stk_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_op_e       kind,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic          ovf_hit,
  input  logic          udf_hit,
  input  logic [DW-1:0] call_target,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          pc_load,
  output logic [DW-1:0] pc_value,
  output logic          ovf_err,
  output logic          udf_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      pc_load  <= 1'b0;
      pc_value <= '0;
      ovf_err  <= 1'b0;
      udf_err  <= 1'b0;
    end else begin
      done     <= push_ok || pop_ok;
      rd_valid <= pop_ok && !op_is_ctrl(kind);
      pc_load  <= (push_ok || pop_ok) && op_is_ctrl(kind);
      if (pop_ok) rd_data <= mem_rdata;
      if (push_ok && op_is_ctrl(kind)) pc_value <= call_target;
      else if (pop_ok && op_is_ctrl(kind)) pc_value <= mem_rdata;
      ovf_err  <= ovf_err || ovf_hit;
      udf_err  <= udf_err || udf_hit;
    end
  end

  // R9: flags are sticky
  assert_sticky_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
  assert_sticky_udf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    udf_err |=> udf_err);
  // R5 R6: a refusal is recorded
  assert_flag_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> (ovf_err && !done));
  assert_flag_udf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    udf_hit |=> (udf_err && !done));
endmodule

// File: rtl/stk_unit.sv
module stk_unit
  import stk_pkg::*;
#(
  parameter int unsigned AW  = 8,
  parameter int unsigned TOP = 255,
  parameter int unsigned BOT = 234
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [AW-1:0] wr_data,
  input  logic [AW-1:0] ret_addr,
  input  logic [AW-1:0] call_target,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic          rd_valid,
  output logic [AW-1:0] rd_data,
  output logic          pc_load,
  output logic [AW-1:0] pc_value,
  output logic [AW-1:0] sp,
  output logic          ovf_err,
  output logic          udf_err
);
  stk_op_e       kind;
  logic          push_ok, pop_ok, ovf_hit, udf_hit;
  logic          full, empty;
  logic [AW-1:0] pop_slot;

  assign kind = stk_op_e'(op_kind);

  stk_ptr #(.AW(AW), .TOP(TOP), .BOT(BOT)) u_ptr (
    .clk(clk), .rst_n(rst_n), .step_dn(push_ok), .step_up(pop_ok),
    .sp(sp), .pop_slot(pop_slot), .full(full), .empty(empty));

  stk_gate u_gate (
    .op_valid(op_valid), .kind(kind), .full(full), .empty(empty),
    .push_ok(push_ok), .pop_ok(pop_ok), .ovf_hit(ovf_hit), .udf_hit(udf_hit));

  stk_resp #(.DW(AW)) u_resp (
    .clk(clk), .rst_n(rst_n), .kind(kind), .push_ok(push_ok), .pop_ok(pop_ok),
    .ovf_hit(ovf_hit), .udf_hit(udf_hit), .call_target(call_target),
    .mem_rdata(mem_rdata), .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
    .pc_load(pc_load), .pc_value(pc_value), .ovf_err(ovf_err), .udf_err(udf_err));

  assign mem_we    = push_ok;
  assign mem_re    = pop_ok;
  assign mem_addr  = pop_ok ? pop_slot : sp;
  assign mem_wdata = op_is_ctrl(kind) ? ret_addr : wr_data;

  // R10: strobes are exclusive and need a request
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re) && ((mem_we || mem_re) -> op_valid));
  // R5: no write into a full window
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !mem_we);
  // R6: no read from an empty window
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !mem_re);
  // R5 R6: a refused operation leaves the pointer alone
  assert_hold_on_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hit || udf_hit) |=> $stable(sp));
endmodule

// File: tb/sim_stk_unit.sv
module sim_stk_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [1:0] op_kind = 2'b00;
  logic [7:0] wr_data = '0, ret_addr = '0, call_target = '0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, rd_data, pc_value, sp;
  logic       mem_we, mem_re, done, rd_valid, pc_load, ovf_err, udf_err;
  logic [7:0] mem [256];
  int checks = 0;
  int errors = 0;
  logic [7:0] c_addr;
  logic       c_we, c_re;

  always #2 clk = ~clk;

  stk_unit u0 (.*);

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  // kind, data, expected address, expected pointer after, expected read byte
  localparam logic [33:0] TBL [8] = '{
    {2'b00, 8'h11, 8'hFF, 8'hFE, 8'h00},
    {2'b00, 8'h22, 8'hFE, 8'hFD, 8'h00},
    {2'b00, 8'h33, 8'hFD, 8'hFC, 8'h00},
    {2'b01, 8'h00, 8'hFD, 8'hFD, 8'h33},
    {2'b00, 8'h44, 8'hFD, 8'hFC, 8'h00},
    {2'b01, 8'h00, 8'hFD, 8'hFD, 8'h44},
    {2'b01, 8'h00, 8'hFE, 8'hFE, 8'h22},
    {2'b01, 8'h00, 8'hFF, 8'hFF, 8'h11}
  };

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // present one operation; captures strobes before the edge
  task automatic op(input logic [1:0] k, input logic [7:0] d, input logic [7:0] tgt);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; wr_data = d; ret_addr = d; call_target = tgt;
    #1;
    c_addr = mem_addr; c_we = mem_we; c_re = mem_re;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0;
    #1;
    chk("R10 idle strobes", {6'b0, mem_we, mem_re}, 8'h00);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sp", sp, 8'hFF);
    chk("R1 flags/pulses", {3'b0, ovf_err, udf_err, done, rd_valid, pc_load}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    for (int v = 0; v < 8; v++) begin
      op(TBL[v][33:32], TBL[v][31:24], 8'h00);
      chk("R2 R3 addr", c_addr, TBL[v][23:16]);
      chk("R10 strobes", {6'b0, c_we, c_re}, (TBL[v][33:32] == 2'b00) ? 8'h02 : 8'h01);
      chk("R2 R3 sp", sp, TBL[v][15:8]);
      chk("R2 R3 done", {7'b0, done}, 8'h01);
      if (TBL[v][33:32] == 2'b01) begin
        chk("R3 rd_valid", {7'b0, rd_valid}, 8'h01);
        chk("R3 rd_data", rd_data, TBL[v][7:0]);
      end
    end
    idle();

    // R6 underflow on empty stack
    op(2'b01, 8'h00, 8'h00);
    chk("R6 no access", {6'b0, c_we, c_re}, 8'h00);
    chk("R6 sp", sp, 8'hFF);
    chk("R6 no done", {7'b0, done}, 8'h00);
    chk("R6 udf_err", {7'b0, udf_err}, 8'h01);
    op(2'b11, 8'h00, 8'h00);
    chk("R6 ret empty no pc_load", {6'b0, pc_load, done}, 8'h00);

    // R4 fill 22 bytes
    for (int i = 0; i < 22; i++) begin
      op(2'b00, 8'hA0 + 8'(i), 8'h00);
      chk("R4 fill addr", c_addr, 8'hFF - 8'(i));
    end
    chk("R4 full sp", sp, 8'hE9);
    chk("R9 udf still set", {7'b0, udf_err}, 8'h01);
    op(2'b00, 8'h5A, 8'h00);
    chk("R5 no write", {7'b0, c_we}, 8'h00);
    chk("R5 sp held", sp, 8'hE9);
    chk("R5 ovf_err no done", {6'b0, ovf_err, done}, 8'h02);
    chk("R5 memory untouched", mem[8'hE9], 8'h00);
    op(2'b10, 8'h5B, 8'h70);
    chk("R5 call full", {6'b0, pc_load, done}, 8'h00);
    for (int i = 21; i >= 0; i--) begin
      op(2'b01, 8'h00, 8'h00);
      chk("R4 lifo data", rd_data, 8'hA0 + 8'(i));
    end
    chk("R4 empty again", sp, 8'hFF);

    // R7 call, R8 return
    op(2'b10, 8'h42, 8'h80);
    chk("R7 addr", c_addr, 8'hFF);
    chk("R7 write", {7'b0, c_we}, 8'h01);
    chk("R7 pc_load/done", {6'b0, pc_load, done}, 8'h03);
    chk("R7 pc_value", pc_value, 8'h80);
    chk("R7 stored ret", mem[8'hFF], 8'h42);
    op(2'b11, 8'h00, 8'h00);
    chk("R8 addr", c_addr, 8'hFF);
    chk("R8 pc_load/done/rd_valid", {5'b0, pc_load, done, rd_valid}, 8'h06);
    chk("R8 pc_value", pc_value, 8'h42);
    chk("R9 flags held", {6'b0, ovf_err, udf_err}, 8'h03);
    idle();

    // R9 reset clears flags
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R9 cleared", {6'b0, ovf_err, udf_err}, 8'h00);
    chk("R1 sp after reset", sp, 8'hFF);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule